// File: doc/BRIEF.md
# Pipeline Hazard and Forwarding Controller

This block makes the hazard decisions for a five-stage in-order integer pipeline whose stages run in the order fetch, decode, execute, memory, writeback. Each cycle it reads the register indices, write enables and load flags of the instructions in decode, execute, memory and writeback. From these it produces operand bypass selects for the execute stage, and for the branch comparator, which sits in decode. It also produces a hold for fetch and decode, a bubble request for execute, and a flush of the fetch/decode register when a branch is taken.

Conditional branches are decided in decode, so a branch operand can still be in flight when the branch needs it. The controller forwards an ALU result from the memory stage into decode. It holds the branch while its producer is still in execute, or while a load producer is in memory. The register file writes in the first half of a cycle and reads in the second, so a value in writeback never needs a bypass into decode. The controller contains only combinational decision logic. It holds no data values and keeps no state.

Top module: `hazard_ctrl`

## Requirements
- R1: `stall_if`, `stall_id` and `bubble_ex` are always equal. Together they form one hold request.
- R2: A load in execute causes a hold when it writes a nonzero register that a source of the decode instruction reads. A source is read when its use flag is 1. This applies to any decode instruction.
- R3: A branch in decode is held when the execute instruction writes a nonzero register that the branch reads. This applies whether the execute instruction is an ALU operation or a load.
- R4: A branch in decode is held when a load in memory writes a nonzero register that the branch reads. A producer in writeback never holds decode.
- R5: An execute operand selects code 2'b10 (memory-stage ALU result) when the non-load instruction in memory writes a nonzero register equal to that operand's index.
- R6: Otherwise, an execute operand selects code 2'b01 (writeback value) when writeback writes a nonzero register equal to its index. When both memory and writeback qualify, memory wins. In all other cases the code is 2'b00 (register file).
- R7: A decode comparator operand selects 2'b10 under the same memory-stage condition as R5. In every other case it selects 2'b00, because it never takes the writeback value.
- R8: Register index 0 never causes a bypass or a hold.
- R9: `flush_ifid` is 1 exactly when decode holds a branch, the branch is taken, and no hold is being requested.
- R10: A producer whose write enable is 0 causes no bypass and no hold.
- R11: A non-branch decode instruction that reads the destination of an ALU (non-load) instruction in execute is not held.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| id_rs1 | input | REG_W | First source index of the decode instruction |
| id_rs2 | input | REG_W | Second source index of the decode instruction |
| id_use_rs1 | input | 1 | Decode instruction reads its first source |
| id_use_rs2 | input | 1 | Decode instruction reads its second source |
| id_branch | input | 1 | Decode instruction is a conditional branch |
| id_taken | input | 1 | Branch outcome from the decode comparator |
| ex_rs1 | input | REG_W | First source index of the execute instruction |
| ex_rs2 | input | REG_W | Second source index of the execute instruction |
| ex_rd | input | REG_W | Destination of the execute instruction |
| ex_wen | input | 1 | Execute instruction writes a register |
| ex_load | input | 1 | Execute instruction is a load |
| mem_rd | input | REG_W | Destination of the memory instruction |
| mem_wen | input | 1 | Memory instruction writes a register |
| mem_load | input | 1 | Memory instruction is a load |
| wb_rd | input | REG_W | Destination of the writeback instruction |
| wb_wen | input | 1 | Writeback instruction writes a register |
| fwd_ex_a | output | 2 | Bypass select, first execute operand |
| fwd_ex_b | output | 2 | Bypass select, second execute operand |
| fwd_id_a | output | 2 | Bypass select, first comparator operand |
| fwd_id_b | output | 2 | Bypass select, second comparator operand |
| stall_if | output | 1 | Hold the fetch stage |
| stall_id | output | 1 | Hold the decode stage |
| bubble_ex | output | 1 | Insert a bubble into execute |
| flush_ifid | output | 1 | Turn the fetch/decode register into a bubble |

## Verification
Every output is a combinational function of the present stage contents. Each result is therefore due in the same cycle as the stimulus, with zero registers between an input and an output. The bench applies each stage pattern just after a rising edge and reads the outputs at the following falling edge, so every sample falls inside the cycle its stimulus belongs to. A sweep then covers all combinations of the control flags with register indices 0 and 1. Directed patterns follow the sweep; they use high indices and replay the one-cycle and two-cycle branch-hold sequences.

// File: rtl/hz_pkg.sv
package hz_pkg;
    typedef enum logic [1:0] {
        FWD_RF  = 2'b00,
        FWD_WB  = 2'b01,
        FWD_MEM = 2'b10
    } fwd_sel_e;

    typedef struct packed {
        logic hold;
        logic flush;
    } ctl_t;
endpackage

// File: rtl/hz_fwd_pick.sv
module hz_fwd_pick
    import hz_pkg::*;
#(
    parameter int REG_W  = 5,
    parameter bit USE_WB = 1'b1
) (
    input  logic [REG_W-1:0] src,
    input  logic [REG_W-1:0] mem_rd,
    input  logic             mem_wen,
    input  logic             mem_load,
    input  logic [REG_W-1:0] wb_rd,
    input  logic             wb_wen,
    output fwd_sel_e         sel
);
    localparam logic [REG_W-1:0] ZERO_REG = '0;

    always_comb begin
        sel = FWD_RF;
        if (src != ZERO_REG) begin
            if (mem_wen && !mem_load && (mem_rd == src)) begin
                sel = FWD_MEM;
            end else if (USE_WB && wb_wen && (wb_rd == src)) begin
                sel = FWD_WB;
            end
        end
    end
endmodule

// File: rtl/hz_stall_detect.sv
module hz_stall_detect #(
    parameter int REG_W = 5
) (
    input  logic [REG_W-1:0] id_rs1,
    input  logic [REG_W-1:0] id_rs2,
    input  logic             id_use_rs1,
    input  logic             id_use_rs2,
    input  logic             id_branch,
    input  logic [REG_W-1:0] ex_rd,
    input  logic             ex_wen,
    input  logic             ex_load,
    input  logic [REG_W-1:0] mem_rd,
    input  logic             mem_wen,
    input  logic             mem_load,
    output logic             hold
);
    localparam logic [REG_W-1:0] ZERO_REG = '0;

    logic dep_ex_d;
    logic dep_mem_d;

    function automatic logic reads_reg(input logic [REG_W-1:0] rd, input logic wen);
        return wen && (rd != ZERO_REG) &&
               ((id_use_rs1 && (rd == id_rs1)) || (id_use_rs2 && (rd == id_rs2)));
    endfunction

    always_comb begin
        dep_ex_d  = reads_reg(ex_rd, ex_wen);
        dep_mem_d = reads_reg(mem_rd, mem_wen);
        hold      = (dep_ex_d && (ex_load || id_branch)) ||
                    (dep_mem_d && mem_load && id_branch);
    end
endmodule

// File: rtl/hazard_ctrl.sv
module hazard_ctrl
    import hz_pkg::*;
#(
    parameter int REG_W = 5
) (
    input  logic [REG_W-1:0] id_rs1,
    input  logic [REG_W-1:0] id_rs2,
    input  logic             id_use_rs1,
    input  logic             id_use_rs2,
    input  logic             id_branch,
    input  logic             id_taken,
    input  logic [REG_W-1:0] ex_rs1,
    input  logic [REG_W-1:0] ex_rs2,
    input  logic [REG_W-1:0] ex_rd,
    input  logic             ex_wen,
    input  logic             ex_load,
    input  logic [REG_W-1:0] mem_rd,
    input  logic             mem_wen,
    input  logic             mem_load,
    input  logic [REG_W-1:0] wb_rd,
    input  logic             wb_wen,
    output logic [1:0]       fwd_ex_a,
    output logic [1:0]       fwd_ex_b,
    output logic [1:0]       fwd_id_a,
    output logic [1:0]       fwd_id_b,
    output logic             stall_if,
    output logic             stall_id,
    output logic             bubble_ex,
    output logic             flush_ifid
);
    localparam int N_OPS = 4;

    logic [REG_W-1:0] op_src [N_OPS];
    fwd_sel_e         op_sel [N_OPS];
    logic             hold_d;
    ctl_t             ctl_d;

    assign op_src[0] = ex_rs1;
    assign op_src[1] = ex_rs2;
    assign op_src[2] = id_rs1;
    assign op_src[3] = id_rs2;

    for (genvar g = 0; g < N_OPS; g++) begin : g_op
        hz_fwd_pick #(
            .REG_W (REG_W),
            .USE_WB(g < 2)
        ) i_pick (
            .src     (op_src[g]),
            .mem_rd  (mem_rd),
            .mem_wen (mem_wen),
            .mem_load(mem_load),
            .wb_rd   (wb_rd),
            .wb_wen  (wb_wen),
            .sel     (op_sel[g])
        );
    end

    hz_stall_detect #(.REG_W(REG_W)) i_stall (
        .id_rs1    (id_rs1),
        .id_rs2    (id_rs2),
        .id_use_rs1(id_use_rs1),
        .id_use_rs2(id_use_rs2),
        .id_branch (id_branch),
        .ex_rd     (ex_rd),
        .ex_wen    (ex_wen),
        .ex_load   (ex_load),
        .mem_rd    (mem_rd),
        .mem_wen   (mem_wen),
        .mem_load  (mem_load),
        .hold      (hold_d)
    );

    always_comb begin
        ctl_d.hold  = hold_d;
        ctl_d.flush = id_branch && id_taken && !hold_d;
    end

    assign fwd_ex_a   = op_sel[0];
    assign fwd_ex_b   = op_sel[1];
    assign fwd_id_a   = op_sel[2];
    assign fwd_id_b   = op_sel[3];
    assign stall_if   = ctl_d.hold;
    assign stall_id   = ctl_d.hold;
    assign bubble_ex  = ctl_d.hold;
    assign flush_ifid = ctl_d.flush;
endmodule

// File: rtl/hz_checks.sv
module hz_checks #(
    parameter int REG_W = 5
) (
    input logic [REG_W-1:0] id_rs1,
    input logic [REG_W-1:0] id_rs2,
    input logic             id_use_rs1,
    input logic             id_use_rs2,
    input logic             id_branch,
    input logic             id_taken,
    input logic [REG_W-1:0] ex_rs1,
    input logic [REG_W-1:0] ex_rs2,
    input logic [REG_W-1:0] ex_rd,
    input logic             ex_wen,
    input logic             ex_load,
    input logic [REG_W-1:0] mem_rd,
    input logic             mem_wen,
    input logic             mem_load,
    input logic [REG_W-1:0] wb_rd,
    input logic             wb_wen,
    input logic [1:0]       fwd_ex_a,
    input logic [1:0]       fwd_ex_b,
    input logic [1:0]       fwd_id_a,
    input logic [1:0]       fwd_id_b,
    input logic             stall_if,
    input logic             stall_id,
    input logic             bubble_ex,
    input logic             flush_ifid
);
    localparam logic [REG_W-1:0] ZERO_REG = '0;

    always_comb begin
        p_hold_agree_r1: assert ((stall_if == stall_id) && (stall_id == bubble_ex))
            else $error("hold outputs disagree");
        p_load_use_r2: assert (!(ex_load && ex_wen && ex_rd != ZERO_REG &&
                                 id_use_rs1 && ex_rd == id_rs1) || stall_id)
            else $error("load-use without hold");
        p_ex_code_r6: assert (fwd_ex_a != 2'b11 && fwd_ex_b != 2'b11)
            else $error("illegal execute select");
        p_id_no_wb_r7: assert (fwd_id_a != 2'b01 && fwd_id_b != 2'b01)
            else $error("decode select took writeback");
        p_x0_quiet_r8: assert ((ex_rs1 != ZERO_REG || fwd_ex_a == 2'b00) &&
                               (id_rs2 != ZERO_REG || fwd_id_b == 2'b00))
            else $error("register 0 bypassed");
        p_flush_hold_r9: assert (!(flush_ifid && stall_id))
            else $error("flush while held");
        p_flush_cause_r9: assert (!flush_ifid || (id_branch && id_taken))
            else $error("flush without taken branch");
        p_no_wen_r10: assert (mem_wen || wb_wen || (fwd_ex_a == 2'b00 && fwd_id_a == 2'b00))
            else $error("bypass without any writer");
    end
    wire unused_ok = &{1'b0, ex_rs2, mem_load, id_use_rs2, wb_rd};
endmodule

bind hazard_ctrl hz_checks #(.REG_W(REG_W)) i_hz_checks (.*);

// File: tb/test_hazard_ctrl.sv
module test_hazard_ctrl;
    localparam int RW = 5;

    logic clk = 1'b0;
    always #4 clk = ~clk;

    logic [RW-1:0] id_rs1, id_rs2, ex_rs1, ex_rs2, ex_rd, mem_rd, wb_rd;
    logic id_use_rs1, id_use_rs2, id_branch, id_taken;
    logic ex_wen, ex_load, mem_wen, mem_load, wb_wen;
    logic [1:0] fwd_ex_a, fwd_ex_b, fwd_id_a, fwd_id_b;
    logic stall_if, stall_id, bubble_ex, flush_ifid;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    hazard_ctrl #(.REG_W(RW)) i_hazard_ctrl (.*);

    task automatic chk(input string req, input int got, input int exp);
        checks++;
        if (got != exp) begin
            fails++;
            $display("FAIL %s got=%0d exp=%0d", req, got, exp);
        end
    endtask

    task automatic clear();
        {id_rs1, id_rs2, ex_rs1, ex_rs2, ex_rd, mem_rd, wb_rd} = '0;
        {id_use_rs1, id_use_rs2, id_branch, id_taken} = '0;
        {ex_wen, ex_load, mem_wen, mem_load, wb_wen} = '0;
    endtask

    // Expected bypass code, worked out from R5/R6/R7/R8/R10.
    function automatic int exp_fwd(input int src, input bit take_wb);
        if (src == 0) return 0;
        if (mem_wen && !mem_load && int'(mem_rd) == src) return 2;
        if (take_wb && wb_wen && int'(wb_rd) == src) return 1;
        return 0;
    endfunction

    // Cycles still to wait before decode may proceed (R2/R3/R4/R11).
    function automatic int exp_wait();
        int w = 0;
        bit dex, dmem;
        dex  = ex_wen && ex_rd != 0 &&
               ((id_use_rs1 && ex_rd == id_rs1) || (id_use_rs2 && ex_rd == id_rs2));
        dmem = mem_wen && mem_rd != 0 &&
               ((id_use_rs1 && mem_rd == id_rs1) || (id_use_rs2 && mem_rd == id_rs2));
        if (id_branch) begin
            if (dex) w = ex_load ? 2 : 1;
            else if (dmem && mem_load) w = 1;
        end else if (dex && ex_load) begin
            w = 1;
        end
        return w;
    endfunction

    task automatic check_all(input string tag);
        int hold;
        hold = (exp_wait() > 0) ? 1 : 0;
        chk({tag, " R2/R3/R4 hold"}, int'(stall_id), hold);
        chk({tag, " R1 agree"}, int'({stall_if, bubble_ex}), hold * 3);
        chk({tag, " R5/R6 ex_a"}, int'(fwd_ex_a), exp_fwd(int'(ex_rs1), 1'b1));
        chk({tag, " R5/R6 ex_b"}, int'(fwd_ex_b), exp_fwd(int'(ex_rs2), 1'b1));
        chk({tag, " R7 id_a"}, int'(fwd_id_a), exp_fwd(int'(id_rs1), 1'b0));
        chk({tag, " R7 id_b"}, int'(fwd_id_b), exp_fwd(int'(id_rs2), 1'b0));
        chk({tag, " R9 flush"}, int'(flush_ifid), int'(id_branch && id_taken && hold == 0));
    endtask

    initial begin
        #(8 * 200000);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        clear();
        @(negedge clk);
        chk("R8 idle hold", int'(stall_id), 0);
        chk("R8 idle ex_a", int'(fwd_ex_a), 0);

        // Sweep: register indices 0/1 with every flag combination.
        for (int v = 0; v < 65536; v++) begin
            @(posedge clk);
            id_rs1 = RW'(v[0]);  id_rs2 = RW'(v[1]);
            ex_rs1 = RW'(v[2]);  ex_rs2 = RW'(v[3]);
            ex_rd  = RW'(v[4]);  mem_rd = RW'(v[5]); wb_rd = RW'(v[6]);
            ex_wen = v[7]; ex_load = v[8]; mem_wen = v[9]; mem_load = v[10];
            wb_wen = v[11]; id_branch = v[12]; id_taken = v[13];
            id_use_rs1 = v[14]; id_use_rs2 = v[15];
            @(negedge clk);
            check_all("sweep");
        end

        // R3/R4: branch on x9 after a load: two held cycles, then free.
        @(posedge clk); clear();
        id_branch = 1; id_taken = 1; id_use_rs1 = 1; id_use_rs2 = 1;
        id_rs1 = 9; id_rs2 = 17; ex_rd = 9; ex_wen = 1; ex_load = 1;
        @(negedge clk); chk("R3 load ahead cycle1 hold", int'(stall_id), 1);
        chk("R9 no flush while held", int'(flush_ifid), 0);
        @(posedge clk); ex_wen = 0; ex_load = 0; ex_rd = 0;
        mem_rd = 9; mem_wen = 1; mem_load = 1;
        @(negedge clk); chk("R4 load in memory hold", int'(stall_id), 1);
        @(posedge clk); mem_wen = 0; mem_load = 0; mem_rd = 0; wb_rd = 9; wb_wen = 1;
        @(negedge clk); chk("R4 writeback no hold", int'(stall_id), 0);
        chk("R7 no wb bypass into decode", int'(fwd_id_a), 0);
        chk("R9 flush when free", int'(flush_ifid), 1);

        // R3/R7: branch after ALU: one hold, then bypass 2'b10.
        @(posedge clk); clear();
        id_branch = 1; id_use_rs1 = 1; id_use_rs2 = 1; id_rs2 = 30;
        ex_rd = 30; ex_wen = 1;
        @(negedge clk); chk("R3 alu ahead hold", int'(stall_id), 1);
        @(posedge clk); ex_wen = 0; ex_rd = 0; mem_rd = 30; mem_wen = 1;
        @(negedge clk); chk("R3 alu then free", int'(stall_id), 0);
        chk("R7 decode bypass from memory", int'(fwd_id_b), 2);
        chk("R9 not taken no flush", int'(flush_ifid), 0);

        // R11: plain ALU consumer after ALU producer is not held.
        @(posedge clk); clear();
        id_use_rs1 = 1; id_rs1 = 12; ex_rd = 12; ex_wen = 1;
        @(negedge clk); chk("R11 no hold", int'(stall_id), 0);

        // R6: memory wins over writeback; R10 write enable low.
        @(posedge clk); clear();
        ex_rs1 = 21; ex_rs2 = 21; mem_rd = 21; mem_wen = 1; wb_rd = 21; wb_wen = 1;
        @(negedge clk); chk("R6 memory priority", int'(fwd_ex_a), 2);
        @(posedge clk); mem_wen = 0;
        @(negedge clk); chk("R6 writeback select", int'(fwd_ex_b), 1);
        @(posedge clk); wb_wen = 0;
        @(negedge clk); chk("R10 disabled writer", int'(fwd_ex_a), 0);

        // R8: register 0 producer in execute, load flag set.
        @(posedge clk); clear();
        id_use_rs1 = 1; id_branch = 1; ex_wen = 1; ex_load = 1;
        @(negedge clk); chk("R8 x0 no hold", int'(stall_id), 0);

        // R2 on second source only.
        @(posedge clk); clear();
        id_use_rs2 = 1; id_rs2 = 5; ex_rd = 5; ex_wen = 1; ex_load = 1;
        @(negedge clk); chk("R2 load-use rs2", int'(stall_id), 1);
        chk("R1 bubble matches", int'(bubble_ex), 1);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule